// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block buffers 24-bit audio samples for one direction of one audio port. In the transmit build the CPU writes samples into a data register and the serialiser takes them out; in the receive build the serialiser writes samples in and the CPU reads them out. A parameter picks the direction when the block is built.

The usable depth is not the raw storage size. A 3-bit size code gives a base capacity of 256 words shifted left by the code, limited to the storage actually present. That capacity is then halved once for every doubling needed to reach the configured channel count, so 3 channels reserve room as if there were 4, and 5 to 7 channels reserve room as if there were 8. The CPU sees a control register (FIFO clear and level-interrupt enable), a status register (fill level in samples per channel plus sticky overrun and underrun flags) and the data register. A level interrupt request tells software when to refill or drain.

Top module: `afifo_sample_fifo`

## Requirements
- R1: After reset the fill level, both error flags, the interrupt enable and `irq` are all zero.
- R2: Samples per channel equal min(256 << cfg_size, 2^AW) halved once per doubling needed to reach the channel count, capped at 256; a channel count of 0 acts as 1 and above 8 acts as 8. The FIFO accepts exactly that many samples times the channel count.
- R3: Status (address 1) bits [16:8] give the stored word count divided by the channel count, rounded down.
- R4: Words leave the FIFO in the order they entered, all 24 bits intact.
- R5: A write into a full FIFO (CPU data write for transmit, serial write for receive) is dropped and sets the sticky overrun flag, status bit 4.
- R6: A read from an empty FIFO (serial read for transmit, CPU data read for receive) returns zero and sets the sticky underrun flag, status bit 0.
- R7: A write to the status register clears each flag whose written bit (4 or 0) is zero and leaves a flag whose written bit is one; a flag event in the same cycle wins.
- R8: Writing control (address 0) with bit 0 set empties the FIFO in that clock; bit 0 always reads back as zero, while bit 20 of the same write is kept.
- R9: With control bit 20 set, `irq` is high in the transmit build while the level is at or below half the per-channel depth, and in the receive build while it is at or above half; with bit 20 clear `irq` is low.
- R10: Data-register accesses in the wrong direction are ignored: a CPU data read in transmit returns zero and removes nothing, a CPU data write in receive stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 3 | Storage size code |
| cfg_chans | input | 4 | Channel count, 1 to 8 |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe (pops data in receive build) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 24 | CPU write data |
| reg_rdata | output | 24 | CPU read data, combinational |
| ser_req | input | 1 | Serialiser take (transmit) or put (receive) strobe |
| ser_wdata | input | 24 | Sample from serialiser (receive build) |
| ser_rdata | output | 24 | Sample to serialiser (transmit build), zero when empty |
| irq | output | 1 | Level interrupt request |

## Verification
The transmit instance is filled under seven size-code and channel-count pairs, including 3, 5 and 8 channels, the per-channel cap and a zero channel count, so rounding to a power of two, the storage limit and the cap each show up as a different final level. A ragged fill of eleven words over two channels separates floor division from rounding in the status field, and stepping across half depth in every configuration shows the exact word where the request flips. Drains compared against a queue expose lost, duplicated or reordered words, and a drain after an overfill shows that the dropped word never entered. The receive instance repeats the fill, level, ordering and empty-read cases from the opposite side, where the request polarity inverts.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int DATA_W    = 24;
  localparam int LVL_W     = 9;
  localparam int LVL_LSB   = 8;
  localparam int LVL_CAP   = 1 << (LVL_W - 1);
  localparam int OVR_BIT   = 4;
  localparam int UND_BIT   = 0;
  localparam int IRQEN_BIT = 20;
  localparam int CLR_BIT   = 0;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // channel count folded into 1..8
  function automatic logic [3:0] norm_chans(input logic [3:0] c);
    if (c == 4'd0) return 4'd1;
    if (c > 4'd8)  return 4'd8;
    return c;
  endfunction

  // number of halvings: channels rounded up to a power of two
  function automatic logic [1:0] chan_shift(input logic [3:0] c);
    logic [3:0] n;
    n = norm_chans(c);
    if (n <= 4'd1) return 2'd0;
    if (n <= 4'd2) return 2'd1;
    if (n <= 4'd4) return 2'd2;
    return 2'd3;
  endfunction

  // samples per channel for a size code and channel count
  function automatic logic [15:0] depth_per_chan(input logic [2:0] code,
                                                 input logic [3:0] c,
                                                 input int         aw);
    logic [16:0] base;
    logic [16:0] store;
    store = 17'd1 << aw;
    base  = 17'd256 << code;
    if (base > store) base = store;
    base = base >> chan_shift(c);
    if (base > 17'(LVL_CAP)) base = 17'(LVL_CAP);
    return base[15:0];
  endfunction

  // stored words expressed as whole samples per channel
  function automatic logic [LVL_W-1:0] level_of(input logic [15:0] words,
                                                input logic [3:0]  c);
    logic [15:0] q;
    q = words / {12'd0, norm_chans(c)};
    return q[LVL_W-1:0];
  endfunction
endpackage

// File: rtl/afifo_geometry.sv
module afifo_geometry
  import afifo_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic [2:0]       cfg_size,
  input  logic [3:0]       cfg_chans,
  output logic [3:0]       chans_n,
  output logic [LVL_W-1:0] depth_pc,
  output logic [LVL_W-1:0] half_pc,
  output logic [AW:0]      usable_words
);
  localparam int WORDS_W = AW + 1;

  logic [15:0] depth_full;
  logic [15:0] prod;

  assign chans_n      = norm_chans(cfg_chans);
  assign depth_full   = depth_per_chan(cfg_size, cfg_chans, AW);
  assign depth_pc     = depth_full[LVL_W-1:0];
  assign half_pc      = depth_pc >> 1;
  assign prod         = depth_full * {12'd0, chans_n};
  assign usable_words = prod[WORDS_W-1:0];
endmodule

// File: rtl/afifo_ring.sv
module afifo_ring #(
  parameter int AW = 9,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  input  logic [AW:0]   usable_words,
  output logic [DW-1:0] dout,
  output logic [AW:0]   words,
  output logic          push_ok,
  output logic          pop_ok
);
  localparam int SLOTS = 1 << AW;

  logic [DW-1:0] mem [SLOTS];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty;

  assign full    = (words >= usable_words);
  assign empty   = (words == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = empty ? '0 : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      words <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      words <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   words <= words + 1'b1;
        2'b01:   words <= words - 1'b1;
        default: words <= words;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr] <= din;
  end

  // R8: a clear leaves nothing behind
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (words == '0));

  // R5: refused write leaves the count alone
  p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !push_ok && !pop_ok && !clr) |=> $stable(words));

  // R6: a read of an empty store does not wrap the count
  p_no_wrap_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (words == '0));
endmodule

// File: rtl/afifo_csr.sv
module afifo_csr
  import afifo_pkg::*;
#(
  parameter bit IS_TX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             stat_wr,
  input  logic             wd_irqen,
  input  logic             wd_clr,
  input  logic             wd_ovr,
  input  logic             wd_und,
  input  logic             ovr_evt,
  input  logic             und_evt,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] half_pc,
  output logic             irq_en,
  output logic             clr_pulse,
  output logic             ovr,
  output logic             und,
  output logic             irq
);
  logic level_hit;

  assign clr_pulse = ctrl_wr && wd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      ovr    <= 1'b0;
      und    <= 1'b0;
    end else begin
      if (ctrl_wr) irq_en <= wd_irqen;
      ovr <= (stat_wr ? (ovr && wd_ovr) : ovr) || ovr_evt;
      und <= (stat_wr ? (und && wd_und) : und) || und_evt;
    end
  end

  generate
    if (IS_TX) begin : g_low_mark
      assign level_hit = (level <= half_pc);
    end else begin : g_high_mark
      assign level_hit = (level >= half_pc);
    end
  endgenerate

  assign irq = irq_en && level_hit;

  // R7: flags hold until a status write with a zero in their bit
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(stat_wr && !wd_ovr)) |=> ovr);
  p_und_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (und && !(stat_wr && !wd_und)) |=> und);
  // R5 / R6: every refused access is recorded
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr);
  p_und_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    und_evt |=> und);
endmodule

// File: rtl/afifo_sample_fifo.sv
module afifo_sample_fifo
  import afifo_pkg::*;
#(
  parameter bit IS_TX = 1'b1,
  parameter int AW    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_size,
  input  logic [3:0]        cfg_chans,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ser_req,
  input  logic [DATA_W-1:0] ser_wdata,
  output logic [DATA_W-1:0] ser_rdata,
  output logic              irq
);
  logic [3:0]        chans_n;
  logic [LVL_W-1:0]  depth_pc, half_pc, level;
  logic [AW:0]       usable_words, words;
  logic              push, pop, push_ok, pop_ok;
  logic [DATA_W-1:0] din, dout, cpu_data;
  logic              ovr_evt, und_evt, clr_pulse;
  logic              irq_en, ovr, und;
  logic              ctrl_wr, stat_wr;
  logic              unused_dir;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);

  afifo_geometry #(.AW(AW)) u_geom (
    .cfg_size     (cfg_size),
    .cfg_chans    (cfg_chans),
    .chans_n      (chans_n),
    .depth_pc     (depth_pc),
    .half_pc      (half_pc),
    .usable_words (usable_words)
  );

  generate
    if (IS_TX) begin : g_tx
      assign push       = reg_wr && (reg_addr == ADDR_DATA);
      assign din        = reg_wdata;
      assign pop        = ser_req;
      assign ser_rdata  = dout;
      assign cpu_data   = '0;
      assign unused_dir = reg_rd ^ (^ser_wdata);
    end else begin : g_rx
      assign push       = ser_req;
      assign din        = ser_wdata;
      assign pop        = reg_rd && (reg_addr == ADDR_DATA);
      assign ser_rdata  = '0;
      assign cpu_data   = dout;
      assign unused_dir = 1'b0;
    end
  endgenerate

  afifo_ring #(.AW(AW), .DW(DATA_W)) u_ring (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr_pulse),
    .push         (push),
    .pop          (pop),
    .din          (din),
    .usable_words (usable_words),
    .dout         (dout),
    .words        (words),
    .push_ok      (push_ok),
    .pop_ok       (pop_ok)
  );

  assign ovr_evt = push && !push_ok;
  assign und_evt = pop && !pop_ok;
  assign level   = level_of(16'(words), chans_n);

  afifo_csr #(.IS_TX(IS_TX)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .stat_wr   (stat_wr),
    .wd_irqen  (reg_wdata[IRQEN_BIT]),
    .wd_clr    (reg_wdata[CLR_BIT]),
    .wd_ovr    (reg_wdata[OVR_BIT]),
    .wd_und    (reg_wdata[UND_BIT]),
    .ovr_evt   (ovr_evt),
    .und_evt   (und_evt),
    .level     (level),
    .half_pc   (half_pc),
    .irq_en    (irq_en),
    .clr_pulse (clr_pulse),
    .ovr       (ovr),
    .und       (und),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata[IRQEN_BIT] = irq_en;
      ADDR_STAT: begin
        reg_rdata[LVL_LSB +: LVL_W] = level;
        reg_rdata[OVR_BIT]          = ovr;
        reg_rdata[UND_BIT]          = und;
      end
      ADDR_DATA: reg_rdata = cpu_data;
      default:   reg_rdata = '0;
    endcase
  end

  // R9: an empty store requests service only on the transmit side
  p_empty_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && (words == '0)) |-> (irq == IS_TX));

  // R10: refused direction never moves the store
  p_wrong_dir_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_req && !(reg_wr && reg_addr == ADDR_DATA && IS_TX)
              && !(reg_rd && reg_addr == ADDR_DATA && !IS_TX) && !clr_pulse)
      |=> $stable(words));
endmodule

// File: tb/test_afifo_sample_fifo.sv
module test_afifo_sample_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int STORE_AW   = 9;
  localparam logic [23:0] IRQEN = 24'h100000;
  localparam logic [23:0] CLRB  = 24'h000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  tx_size = '0,  rx_size = '0;
  logic [3:0]  tx_chans = 4'd1, rx_chans = 4'd1;
  logic        tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0;
  logic [1:0]  tx_addr = '0, rx_addr = '0;
  logic [23:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic        tx_ser_req = 0, rx_ser_req = 0;
  logic [23:0] tx_ser_wdata = '0, rx_ser_wdata = '0, tx_ser_rdata, rx_ser_rdata;
  logic        tx_irq, rx_irq;

  afifo_sample_fifo #(.IS_TX(1'b1), .AW(STORE_AW)) i_afifo_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_size(tx_size), .cfg_chans(tx_chans),
    .reg_wr(tx_wr), .reg_rd(tx_rd), .reg_addr(tx_addr), .reg_wdata(tx_wdata),
    .reg_rdata(tx_rdata), .ser_req(tx_ser_req), .ser_wdata(tx_ser_wdata),
    .ser_rdata(tx_ser_rdata), .irq(tx_irq));

  afifo_sample_fifo #(.IS_TX(1'b0), .AW(STORE_AW)) i_afifo_sample_fifo_rx (
    .clk(clk), .rst_n(rst_n), .cfg_size(rx_size), .cfg_chans(rx_chans),
    .reg_wr(rx_wr), .reg_rd(rx_rd), .reg_addr(rx_addr), .reg_wdata(rx_wdata),
    .reg_rdata(rx_rdata), .ser_req(rx_ser_req), .ser_wdata(rx_ser_wdata),
    .ser_rdata(rx_ser_rdata), .irq(rx_irq));

  int n_checks = 0, n_errors = 0;
  logic [23:0] tx_q[$], rx_q[$];
  int tx_words = 0, rx_words = 0;
  logic [23:0] mon_exp;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nch(input int c);
    if (c == 0) return 1;
    if (c > 8) return 8;
    return c;
  endfunction

  function automatic int exp_depth(input int code, input int c);
    int b = 256 << code;
    if (b > (1 << STORE_AW)) b = 1 << STORE_AW;
    for (int k = 1; k < nch(c); k = k * 2) b = b / 2;
    if (b > 256) b = 256;
    return b;
  endfunction

  function automatic logic [23:0] stat_word(input int lvl, input bit o, input bit u);
    return 24'(lvl << 8) | (o ? 24'h10 : 24'h0) | (u ? 24'h1 : 24'h0);
  endfunction

  task automatic bus_wr(input bit rx, input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    if (rx) begin rx_wr = 1; rx_addr = a; rx_wdata = d; end
    else    begin tx_wr = 1; tx_addr = a; tx_wdata = d; end
    @(negedge clk);
    rx_wr = 0; tx_wr = 0;
  endtask

  task automatic bus_rd(input bit rx, input logic [1:0] a, output logic [23:0] v);
    @(negedge clk);
    if (rx) begin rx_rd = 1; rx_addr = a; end
    else    begin tx_rd = 1; tx_addr = a; end
    #1 v = rx ? rx_rdata : tx_rdata;
    @(negedge clk);
    rx_rd = 0; tx_rd = 0;
  endtask

  // driver: CPU write into the transmit FIFO, model updates the scoreboard
  task automatic tx_drive(input logic [23:0] d);
    if (tx_words < exp_depth(tx_size, tx_chans) * nch(tx_chans)) begin
      tx_q.push_back(d);
      tx_words++;
    end
    bus_wr(0, 2'd2, d);
  endtask

  task automatic tx_pop(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tx_ser_req = 1;
      @(negedge clk); tx_ser_req = 0;
    end
  endtask

  // monitor: compare every word the serialiser takes
  always @(negedge clk) begin
    #2;
    if (tx_ser_req) begin
      if (tx_q.size() == 0) check("R6 tx empty take gives zero", tx_ser_rdata, 0);
      else begin
        mon_exp = tx_q.pop_front();
        tx_words--;
        check("R4 tx order", tx_ser_rdata, mon_exp);
      end
    end
  end

  task automatic rx_push(input logic [23:0] d);
    if (rx_words < exp_depth(rx_size, rx_chans) * nch(rx_chans)) begin
      rx_q.push_back(d);
      rx_words++;
    end
    @(negedge clk); rx_ser_req = 1; rx_ser_wdata = d;
    @(negedge clk); rx_ser_req = 0;
  endtask

  task automatic rx_read_check(input string req);
    logic [23:0] v, e;
    e = 24'h0;
    if (rx_q.size() != 0) begin e = rx_q.pop_front(); rx_words--; end
    bus_rd(1, 2'd2, v);
    check(req, v, e);
  endtask

  task automatic clear_port(input bit rx);
    bus_wr(rx, 2'd0, IRQEN | CLRB);
    bus_wr(rx, 2'd1, 24'h0);
    if (rx) begin rx_q.delete(); rx_words = 0; end
    else    begin tx_q.delete(); tx_words = 0; end
  endtask

  task automatic tx_fill(input int code, input int c, input int tag);
    logic [23:0] v;
    int d, u;
    clear_port(0);
    tx_size = 3'(code); tx_chans = 4'(c);
    d = exp_depth(code, c);
    u = d * nch(c);
    for (int i = 0; i <= u; i++) begin
      tx_drive(24'(tag * 24'h010000 + i));
      if (i + 1 == (d / 2) * nch(c)) check("R9 tx irq at half", tx_irq, 1);
      if (i + 1 == (d / 2 + 1) * nch(c)) check("R9 tx irq above half", tx_irq, 0);
    end
    bus_rd(0, 2'd1, v);
    check("R2 R5 tx full level and overrun", v, stat_word(d, 1, 0));
  endtask

  initial begin
    logic [23:0] v;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    bus_rd(0, 2'd1, v); check("R1 tx status", v, 0);
    bus_rd(0, 2'd0, v); check("R1 tx control", v, 0);
    check("R1 tx irq", tx_irq, 0);
    bus_rd(1, 2'd1, v); check("R1 rx status", v, 0);
    check("R1 rx irq", rx_irq, 0);

    // transmit: ragged fill over two channels
    tx_size = 3'd0; tx_chans = 4'd2;
    bus_wr(0, 2'd0, IRQEN);
    check("R9 tx irq when empty", tx_irq, 1);
    for (int i = 0; i < 11; i++) tx_drive(24'(i * 24'h10101) ^ 24'hA5A5A5);
    bus_rd(0, 2'd1, v); check("R3 tx floor level", v, stat_word(5, 0, 0));
    bus_rd(0, 2'd2, v); check("R10 tx cpu data read is zero", v, 0);
    bus_rd(0, 2'd1, v); check("R10 tx read removed nothing", v, stat_word(5, 0, 0));
    tx_pop(11);
    check("R4 tx all words came out", tx_q.size(), 0);
    tx_pop(1);
    bus_rd(0, 2'd1, v); check("R6 tx underrun flag", v, stat_word(0, 0, 1));

    // R7 sticky flag handling
    bus_wr(0, 2'd1, 24'h1);
    bus_rd(0, 2'd1, v); check("R7 written one keeps flag", v, stat_word(0, 0, 1));
    bus_wr(0, 2'd1, 24'h10);
    bus_rd(0, 2'd1, v); check("R7 written zero clears flag", v, 0);

    // R2 depth under several geometries; drop on full (R5)
    tx_fill(0, 3, 1);
    tx_pop(192);
    check("R5 dropped word never stored", tx_q.size(), 0);
    bus_rd(0, 2'd1, v); check("R4 tx drained", v[16:8], 0);
    tx_fill(1, 2, 2);
    tx_fill(1, 1, 3);
    tx_fill(0, 8, 4);
    tx_fill(0, 5, 5);
    tx_fill(2, 4, 6);
    tx_fill(0, 0, 7);

    // R8 clear: empties, self-clears bit 0, keeps enable
    bus_wr(0, 2'd0, IRQEN | CLRB);
    tx_q.delete(); tx_words = 0;
    bus_rd(0, 2'd1, v); check("R8 clear empties", v[16:8], 0);
    bus_rd(0, 2'd0, v); check("R8 control readback", v, IRQEN);
    bus_wr(0, 2'd0, 24'h0);
    check("R9 tx irq off when disabled", tx_irq, 0);

    // receive side
    rx_size = 3'd1; rx_chans = 4'd8;
    bus_wr(1, 2'd0, IRQEN);
    check("R9 rx irq low when empty", rx_irq, 0);
    for (int i = 0; i < 67; i++) rx_push(24'hC00000 + 24'(i * 7));
    bus_rd(1, 2'd1, v); check("R3 rx floor level", v, stat_word(8, 0, 0));
    bus_wr(1, 2'd2, 24'h123456);
    bus_rd(1, 2'd1, v); check("R10 rx cpu write ignored", v, stat_word(8, 0, 0));
    for (int i = 0; i < 4; i++) rx_read_check("R4 rx order");
    for (int i = 0; i < 256 - 63; i++) rx_push(24'hD00000 + 24'(i));
    bus_rd(1, 2'd1, v); check("R3 rx level at half", v, stat_word(32, 0, 0));
    check("R9 rx irq at half", rx_irq, 1);
    rx_read_check("R4 rx order");
    check("R9 rx irq below half", rx_irq, 0);
    for (int i = 0; i < 258; i++) rx_push(24'hE00000 + 24'(i));
    bus_rd(1, 2'd1, v); check("R2 R5 rx full and overrun", v, stat_word(64, 1, 0));
    for (int i = 0; i < 3; i++) rx_read_check("R4 rx order after full");
    clear_port(1);
    rx_read_check("R6 rx empty read gives zero");
    bus_rd(1, 2'd1, v); check("R6 rx underrun flag", v, stat_word(0, 0, 1));

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule